// File: doc/BRIEF.md
# Byte-Lane Static RAM Cycle Controller

This block sits between an on-chip request port and an external asynchronous static RAM with an 18-bit word address and a 16-bit data bus. A client offers one access at a time with a valid/ready handshake. Each access carries a read/write flag, an address, write data and a two-bit lane mask. The controller then plays out the RAM cycle on the active-low chip enable, write enable, output enable and per-byte select pins. It also drives the direction control of the shared data bus.

All RAM timing is counted in whole clock cycles. Parameters give the clock period and the RAM's minimum intervals in picoseconds, and each interval is rounded up to at least one clock. Reads end with a single-cycle valid pulse that carries the captured word. Lanes that the mask left out come back as zero. Writes touch only the lanes whose select line is pulled low.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, and whenever the controller is idle, chip enable, write enable, output enable and both byte selects are high, the data bus is not driven, `req_ready` is high and `rd_valid` is low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the access is finished. It stays low for exactly RD_CYC cycles on a read and 1 + WP_CYC + HOLD_CYC cycles on a write.
- R3: A read holds chip enable and output enable low, with write enable high, for exactly RD_CYC = ceil(tRC / clock period) cycles. The data pins are sampled on the edge that ends this interval. In the next cycle `rd_valid` is high for exactly one cycle, and `req_ready` is high in that same cycle.
- R4: Mask bit 0 selects the lower lane (data bits 7:0) and mask bit 1 the upper lane (bits 15:8); a set bit pulls the lane's active-low select (`mem_be_n[0]` or `mem_be_n[1]`) low for the whole access. On a read, any lane whose mask bit is clear returns zero in `rd_data`.
- R5: A write starts with one setup cycle in which chip enable and the selects are low while write enable is still high. The write pulse follows, then a hold period. Write enable is never low during a read.
- R6: The write pulse lasts exactly WP_CYC cycles, the largest of ceil(tWP), ceil(tDW) and ceil(tWHZ + tDW). Write data is driven and held stable for the whole pulse.
- R7: A lane whose select is high during a write keeps its stored contents. A write with a zero mask changes nothing.
- R8: The controller never drives the data bus while output enable is low. Output enable is high in the cycle before the bus drive starts. The bus drive is released at least one cycle before output enable goes low.
- R9: The address is presented no later than chip enable falls, and it stays constant for as long as chip enable is low.
- R10: On a write, chip enable is low for 1 + WP_CYC + HOLD_CYC cycles, where HOLD_CYC = max(1, ceil(tWC) - 1 - WP_CYC). This period is never shorter than ceil(tWC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Captured read word, unselected lanes zero |
| mem_addr | output | 18 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM byte selects, active low, bit 0 lower lane |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 16 | Data from the RAM pins |

## Verification
The situation hardest to reach from the ports is a partial-lane write to a word that already holds distinct data in both bytes, followed by reads under every other mask. Only that sequence shows whether an unselected lane was left alone and whether unselected read lanes are zeroed. The bench first fills sixteen words, then sweeps every write mask against every read mask on each word. A RAM model returns junk until the access interval has fully elapsed, and it returns a fixed non-zero pattern on deselected lanes. A capture that is too early, or a missing lane gate, therefore shows up as a wrong word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_WSETUP,
        SEQ_WPULSE,
        SEQ_WHOLD
    } seq_state_e;

    // Whole clock cycles covering a span, never below one.
    function automatic int clk_cycles(input int span_ps, input int clk_ps);
        int c;
        c = (span_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int LANES    = 2,
    parameter int RD_CYC   = 5,
    parameter int WP_CYC   = 5,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              sample_stb,
    output logic [LANES-1:0]  lane_sel
);

    localparam int CNT_MAX = imax(imax(RD_CYC, WP_CYC), HOLD_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  be_n;
        logic              dq_oe;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.lanes = req_mask;
                    s_d.ce_n  = 1'b0;
                    s_d.be_n  = ~req_mask;
                    if (req_write) begin
                        s_d.st   = SEQ_WSETUP;
                        s_d.oe_n = 1'b1;
                        s_d.cnt  = '0;
                    end else begin
                        s_d.st   = SEQ_READ;
                        s_d.oe_n = 1'b0;
                        s_d.cnt  = RD_LOAD;
                    end
                end
            end
            SEQ_READ: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = SEQ_IDLE;
                    s_d.ce_n = 1'b1;
                    s_d.oe_n = 1'b1;
                    s_d.be_n = '1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SEQ_WSETUP: begin
                s_d.st    = SEQ_WPULSE;
                s_d.we_n  = 1'b0;
                s_d.dq_oe = 1'b1;
                s_d.cnt   = WP_LOAD;
            end
            SEQ_WPULSE: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = SEQ_WHOLD;
                    s_d.we_n = 1'b1;
                    s_d.cnt  = HOLD_LOAD;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SEQ_WHOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = SEQ_IDLE;
                    s_d.ce_n  = 1'b1;
                    s_d.be_n  = '1;
                    s_d.dq_oe = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                s_d.st    = SEQ_IDLE;
                s_d.ce_n  = 1'b1;
                s_d.we_n  = 1'b1;
                s_d.oe_n  = 1'b1;
                s_d.be_n  = '1;
                s_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= SEQ_IDLE;
            s_q.cnt   <= '0;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.lanes <= '0;
            s_q.ce_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
            s_q.be_n  <= '1;
            s_q.dq_oe <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.st == SEQ_IDLE);
    assign mem_addr   = s_q.addr;
    assign mem_ce_n   = s_q.ce_n;
    assign mem_we_n   = s_q.we_n;
    assign mem_oe_n   = s_q.oe_n;
    assign mem_be_n   = s_q.be_n;
    assign mem_dq_out = s_q.wdata;
    assign mem_dq_oe  = s_q.dq_oe;
    assign sample_stb = (s_q.st == SEQ_READ) && (s_q.cnt == '0);
    assign lane_sel   = s_q.lanes;

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int LANE_W = DATA_W / LANES;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_regs_t;

    cap_regs_t c_d, c_q;
    logic [DATA_W-1:0] gated;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign gated[g*LANE_W +: LANE_W] =
            lane_sel[g] ? mem_dq_in[g*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        c_d     = c_q;
        c_d.vld = sample_stb;
        if (sample_stb) c_d.data = gated;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.vld  <= 1'b0;
            c_q.data <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_valid = c_q.vld;
    assign rd_data  = c_q.data;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int T_RC_PS       = 20000,
    parameter int T_WC_PS       = 20000,
    parameter int T_WP_PS       = 11000,
    parameter int T_DW_PS       = 9000,
    parameter int T_WHZ_PS      = 9000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [1:0]        mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int LANES    = 2;
    localparam int RD_CYC   = clk_cycles(T_RC_PS, CLK_PERIOD_PS);
    localparam int WP_CYC   = imax(imax(clk_cycles(T_WP_PS, CLK_PERIOD_PS),
                                        clk_cycles(T_DW_PS, CLK_PERIOD_PS)),
                                   clk_cycles(T_WHZ_PS + T_DW_PS, CLK_PERIOD_PS));
    localparam int WC_CYC   = clk_cycles(T_WC_PS, CLK_PERIOD_PS);
    localparam int HOLD_CYC = imax(1, WC_CYC - 1 - WP_CYC);

    logic             sample_stb;
    logic [LANES-1:0] lane_sel;

    sram_cycle_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LANES    (LANES),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .req_ready  (req_ready),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_be_n   (mem_be_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .sample_stb (sample_stb),
        .lane_sel   (lane_sel)
    );

    sram_read_capture #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .lane_sel   (lane_sel),
        .mem_dq_in  (mem_dq_in),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int RD_CYC = 5,
    parameter int WP_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [1:0]        mem_be_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    logic [31:0] we_lo_cnt;
    logic [31:0] oe_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_lo_cnt <= '0;
        end else begin
            we_lo_cnt <= mem_we_n ? 32'd0 : we_lo_cnt + 32'd1;
            oe_lo_cnt <= mem_oe_n ? 32'd0 : oe_lo_cnt + 32'd1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));

    // R2
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R3
    rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_lo_cnt == 32'(RD_CYC)));

    // R5
    we_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    // R6
    we_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == 32'(WP_CYC)));

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    // R8
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R8
    oe_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // R8
    release_before_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;

    localparam int CLK_PS  = 4000;
    localparam int RD_E    = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int WP_A    = (11000 + CLK_PS - 1) / CLK_PS;
    localparam int WP_B    = (18000 + CLK_PS - 1) / CLK_PS;
    localparam int WP_E    = (WP_A > WP_B) ? WP_A : WP_B;
    localparam int WC_E    = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int HOLD_E  = (WC_E - 1 - WP_E > 1) ? (WC_E - 1 - WP_E) : 1;
    localparam int WR_LEN  = 1 + WP_E + HOLD_E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    always #2 clk = ~clk;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit timeout = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) timeout = 1'b1;
    end

    // RAM model: junk until the access interval has elapsed, pattern on idle lanes
    logic [15:0] ram_m [16];
    logic [15:0] exp_m [16];
    int acc_cnt = 0;

    always @(posedge clk)
        acc_cnt <= (!mem_ce_n && !mem_oe_n && mem_we_n) ? acc_cnt + 1 : 0;

    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && acc_cnt >= RD_E - 1)
            mem_dq_in = {mem_be_n[1] ? 8'hA5 : ram_m[mem_addr[3:0]][15:8],
                         mem_be_n[0] ? 8'h5A : ram_m[mem_addr[3:0]][7:0]};
        else
            mem_dq_in = 16'hC3C3;
    end

    // Expectations for the access in flight
    bit          cur_write = 1'b0;
    logic [17:0] cur_addr  = '0;
    logic [15:0] cur_wdata = '0;
    logic [1:0]  cur_mask  = '0;

    logic prev_ce_n = 1'b1, prev_we_n = 1'b1, prev_oe_n = 1'b1;
    logic prev_dq_oe = 1'b0, prev_rv = 1'b0;
    int   we_run = 0, ce_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) begin
                check(mem_addr == cur_addr, "R9", 32'(mem_addr), 32'(cur_addr));
                check(mem_be_n == ~cur_mask, "R7", 32'(mem_be_n), 32'(~cur_mask));
            end
            if (!mem_ce_n && prev_ce_n && cur_write)
                check(mem_we_n, "R5", 32'(mem_we_n), 32'd1);
            if (!mem_oe_n)
                check(!mem_dq_oe, "R8", 32'(mem_dq_oe), 32'd0);
            if (mem_dq_oe && !prev_dq_oe)
                check(prev_oe_n && mem_oe_n, "R8", 32'(prev_oe_n), 32'd1);
            if (!mem_we_n) begin
                check(cur_write, "R5", 32'(cur_write), 32'd1);
                check(mem_dq_oe && mem_dq_out == cur_wdata, "R6",
                      32'(mem_dq_out), 32'(cur_wdata));
                if (!mem_ce_n && mem_dq_oe) begin
                    if (!mem_be_n[0]) ram_m[mem_addr[3:0]][7:0]  = mem_dq_out[7:0];
                    if (!mem_be_n[1]) ram_m[mem_addr[3:0]][15:8] = mem_dq_out[15:8];
                end
                we_run++;
            end else if (!prev_we_n) begin
                check(we_run == WP_E, "R6", 32'(we_run), 32'(WP_E));
                we_run = 0;
            end
            if (!mem_ce_n) ce_run++;
            else if (!prev_ce_n) begin
                if (cur_write) check(ce_run == WR_LEN && ce_run >= WC_E, "R10",
                                     32'(ce_run), 32'(WR_LEN));
                else           check(ce_run == RD_E, "R3", 32'(ce_run), 32'(RD_E));
                ce_run = 0;
            end
            if (rd_valid && prev_rv) check(1'b0, "R3", 32'd1, 32'd0);
        end
        prev_ce_n  = mem_ce_n;
        prev_we_n  = mem_we_n;
        prev_oe_n  = mem_oe_n;
        prev_dq_oe = mem_dq_oe;
        prev_rv    = rd_valid;
    end

    task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m, output logic [15:0] got,
                         output bit got_v, output int busy);
        cur_write = wr; cur_addr = a; cur_wdata = d; cur_mask = m;
        check(req_ready, "R2", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~d;
        busy = 0;
        while (!req_ready && !timeout) begin
            busy++;
            @(negedge clk);
        end
        got   = rd_data;
        got_v = rd_valid;
        @(negedge clk);
    endtask

    function automatic logic [17:0] addr_of(input int i);
        if (i == 15) return 18'h3FFFF;
        return {14'((i * 2643) ^ (i * 5)), 4'(i)};
    endfunction

    function automatic logic [15:0] lmask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    initial begin
        logic [15:0] got;
        bit          gv;
        int          busy;
        int          wcount;
        wcount = 0;
        for (int k = 0; k < 16; k++) begin ram_m[k] = 16'h0000; exp_m[k] = 16'h0000; end

        repeat (3) @(negedge clk);
        // R1 while in reset
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe
              && req_ready && !rd_valid, "R1",
              {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 32'h3E);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 idle after reset
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe
              && req_ready && !rd_valid, "R1",
              {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 32'h3E);

        // Fill every word with full-lane writes
        for (int i = 0; i < 16 && !timeout; i++) begin
            logic [15:0] d;
            d = 16'(i * 16'h1F3B + 16'h2468);
            do_op(1'b1, addr_of(i), d, 2'b11, got, gv, busy);
            exp_m[i] = d;
            check(busy == WR_LEN, "R2", 32'(busy), 32'(WR_LEN));
        end

        // Every write mask against every read mask on every word
        for (int i = 0; i < 16 && !timeout; i++) begin
            for (int m = 0; m < 4 && !timeout; m++) begin
                logic [15:0] d;
                wcount++;
                d = 16'(wcount * 16'h9E37 + 16'h1357);
                do_op(1'b1, addr_of(i), d, 2'(m), got, gv, busy);
                exp_m[i] = (exp_m[i] & ~lmask(2'(m))) | (d & lmask(2'(m)));
                check(busy == WR_LEN, "R2", 32'(busy), 32'(WR_LEN));
                check(!gv, "R3", 32'(gv), 32'd0);
                for (int r = 0; r < 4 && !timeout; r++) begin
                    do_op(1'b0, addr_of(i), 16'h0000, 2'(r), got, gv, busy);
                    check(busy == RD_E, "R2", 32'(busy), 32'(RD_E));
                    check(gv, "R3", 32'(gv), 32'd1);
                    if (r == 3)
                        check(got == exp_m[i], "R7", 32'(got), 32'(exp_m[i]));
                    else
                        check(got == (exp_m[i] & lmask(2'(r))), "R4",
                              32'(got), 32'(exp_m[i] & lmask(2'(r))));
                end
            end
        end

        if (timeout) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule